// File: doc/BRIEF.md
# Configuration Memory Check-Word Engine

This block computes a 16-bit check word over a region of a byte-wide configuration memory and then stores the result back into that memory. A start pulse supplies a first address, a byte count and a destination address. The engine streams reads through a synchronous memory port, one per cycle. It folds the bytes into a nibble-based 16-bit CRC and, when the count is odd, applies one extra step for the trailing byte. It then writes the two result bytes and pulses done.

The fold works on 16-bit big-endian words taken at every byte offset, so each word shares a byte with the next one. The engine keeps the previous byte in a register so that each byte is fetched from memory only once. A typical use is to seal a parameter header after software or a boot sequencer has filled it. For example, the check can cover 0xF8 bytes from address 0 and be stored at offset 0xFC.

Top module: `cfg_crc_engine`

## Requirements
- R1: After reset, busy, done, mem_rd_en and mem_wr_en are all low.
- R2: A start pulse seen while idle captures start_addr, byte_count and dest_addr. Busy is high from the next cycle up to and including the done cycle. A start pulse while busy has no effect on reads, writes or the result.
- R3: Reads are issued on consecutive cycles, starting the cycle after the accepted start. They begin at start_addr and the address rises by one each cycle. Read data is taken one cycle after its request.
- R4: The number of reads is 0 for a zero count. Otherwise it is the count with its least significant bit forced to 1. An even non-zero count therefore reads one byte past the region.
- R5: The check register starts at 0xFFFF. A step with value v computes p = crc XOR v, a = p[3:0], b = p[7:4] XOR a. The new value is (crc >> 8) XOR (a << 3) XOR (a << 8) XOR b XOR (b << 7) XOR (b << 12), kept to 16 bits.
- R6: Let E be the count with bit 0 cleared. For i from 0 to E-1, one step is applied with v = byte[start+i] * 256 + byte[start+i+1].
- R7: For an odd count, one final step is applied with v = byte[start+E] * 256.
- R8: The result is written in two consecutive cycles. The first write puts result bits 15:8 at dest_addr. The second puts bits 7:0 at dest_addr+1.
- R9: Done is high for exactly one cycle, the cycle after the low-byte write. For a zero count it is the third cycle after start. Otherwise it is cycle N+4 (plus one more for an odd count), where N is the read count. Busy is low in the following cycle.
- R10: A zero count performs no read and writes 0xFFFF.
- R11: Read and write addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| start_addr | input | ADDR_W | First byte of the covered region |
| byte_count | input | CNT_W | Number of bytes covered |
| dest_addr | input | ADDR_W | Address of the result's high byte |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 8 | Memory write data |

## Verification
The bench builds the engine with ADDR_W = 8 and CNT_W = 9, so the memory has only 256 bytes. This makes wrapping reachable: a region that runs past the top of memory, a result pair split across address 0xFF and 0x00, and the largest count of 511, which sweeps the address space almost twice. The same settings still cover the 0xF8-byte header sealed at offset 0xFC. The smallest counts (0 to 3) are run to pin down the seed, the tail step and the extra read made for even counts.

// File: rtl/cfg_crc_pkg.sv
// Shared types and the fold step for the check-word engine.
// Assumes 8-bit memory bytes and a 16-bit check word.
package cfg_crc_pkg;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_TAIL,
        ST_WR_HI,
        ST_WR_LO,
        ST_FINISH
    } ctl_state_e;

    // One nibble-folding step of the check word.
    function automatic logic [15:0] crc_fold(input logic [15:0] acc, input logic [15:0] word);
        logic [15:0] mix;
        logic [15:0] lo;
        logic [15:0] hi;
        mix = acc ^ word;
        lo  = {12'h000, mix[3:0]};
        hi  = {12'h000, mix[7:4] ^ mix[3:0]};
        return {8'h00, acc[15:8]} ^ (lo << 3) ^ (lo << 8) ^ hi ^ (hi << 7) ^ (hi << 12);
    endfunction

endpackage

// File: rtl/cfg_crc_reader.sv
// Read issuer: after launch, issues one read per cycle for nbytes
// consecutive addresses starting at base_addr (wrapping).
// Assumes launch only arrives while no reads are outstanding.
module cfg_crc_reader #(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  nbytes,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);

    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;

    // Track remaining reads and the next address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            addr_q <= '0;
        end else if (launch) begin
            left_q <= nbytes;
            addr_q <= base_addr;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + 1'b1;
        end
    end

    assign rd_en   = (left_q != '0);
    assign rd_addr = addr_q;

endmodule

// File: rtl/cfg_crc_accum.sv
// Accumulator: receives bytes one cycle after each read, keeps the
// previous byte, folds each overlapping big-endian word and the optional
// padded tail into the check word. Flags the last expected byte.
// Assumes nbytes is stable and non-zero while bytes arrive.
module cfg_crc_accum #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] nbytes,
    input  logic             rd_issue,
    input  logic [7:0]       rd_data,
    input  logic             tail_en,
    output logic [15:0]      crc,
    output logic             last_byte
);
    import cfg_crc_pkg::*;

    logic             valid_q;
    logic [CNT_W-1:0] idx_q;
    logic [7:0]       prev_q;
    logic [15:0]      crc_q;

    // Align the data-valid flag with the one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= rd_issue;
    end

    // Count received bytes and hold the latest one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            prev_q <= '0;
        end else if (clear) begin
            idx_q  <= '0;
        end else if (valid_q) begin
            idx_q  <= idx_q + 1'b1;
            prev_q <= rd_data;
        end
    end

    // Fold words and the padded tail into the check word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= CRC_SEED;
        end else if (tail_en) begin
            crc_q <= crc_fold(crc_q, {prev_q, 8'h00});
        end else if (valid_q && idx_q != '0) begin
            crc_q <= crc_fold(crc_q, {prev_q, rd_data});
        end
    end

    assign crc       = crc_q;
    assign last_byte = valid_q && (idx_q == nbytes - 1'b1);

endmodule

// File: rtl/cfg_crc_ctrl.sv
// Sequencer: accepts a start while idle, waits for the last byte,
// adds the tail step for odd counts, then steps through the two
// write cycles and the done cycle.
// Assumes last_byte arrives exactly once per non-zero fetch.
module cfg_crc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic zero_count,
    input  logic odd_count,
    input  logic last_byte,
    output logic accept,
    output logic tail_en,
    output logic wr_hi,
    output logic wr_lo,
    output logic done,
    output logic busy
);
    import cfg_crc_pkg::*;

    ctl_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = zero_count ? ST_WR_HI : ST_FETCH;
            ST_FETCH:  if (last_byte) state_d = odd_count ? ST_TAIL : ST_WR_HI;
            ST_TAIL:   state_d = ST_WR_HI;
            ST_WR_HI:  state_d = ST_WR_LO;
            ST_WR_LO:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign accept  = (state_q == ST_IDLE) && start;
    assign tail_en = (state_q == ST_TAIL);
    assign wr_hi   = (state_q == ST_WR_HI);
    assign wr_lo   = (state_q == ST_WR_LO);
    assign done    = (state_q == ST_FINISH);
    assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/cfg_crc_engine.sv
// Top: computes the 16-bit check word over a memory region and writes
// it back high byte first. Assumes a synchronous byte memory with one
// cycle of read latency and that writes never collide with reads.
module cfg_crc_engine #(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [ADDR_W-1:0] dest_addr,
    output logic              busy,
    output logic              done,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data
);

    logic              accept, tail_en, wr_hi, wr_lo, last_byte;
    logic              zero_count;
    logic [CNT_W-1:0]  need_reads;
    logic [CNT_W-1:0]  nbytes_q;
    logic              odd_q;
    logic [ADDR_W-1:0] dest_q;
    logic [15:0]       crc;

    // Reads needed: none for zero, else the count with bit 0 set.
    assign zero_count = (byte_count == '0);
    assign need_reads = zero_count ? '0 : (byte_count | {{(CNT_W-1){1'b0}}, 1'b1});

    // Capture the job parameters on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nbytes_q <= '0;
            odd_q    <= 1'b0;
            dest_q   <= '0;
        end else if (accept) begin
            nbytes_q <= need_reads;
            odd_q    <= byte_count[0];
            dest_q   <= dest_addr;
        end
    end

    cfg_crc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .zero_count (zero_count),
        .odd_count  (odd_q),
        .last_byte  (last_byte),
        .accept     (accept),
        .tail_en    (tail_en),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .done       (done),
        .busy       (busy)
    );

    cfg_crc_reader #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (accept),
        .base_addr (start_addr),
        .nbytes    (need_reads),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr)
    );

    cfg_crc_accum #(.CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .nbytes    (nbytes_q),
        .rd_issue  (mem_rd_en),
        .rd_data   (mem_rd_data),
        .tail_en   (tail_en),
        .crc       (crc),
        .last_byte (last_byte)
    );

    // Write-back: high byte at dest, then low byte at dest+1.
    assign mem_wr_en   = wr_hi | wr_lo;
    assign mem_wr_addr = wr_lo ? dest_q + 1'b1 : dest_q;
    assign mem_wr_data = wr_lo ? crc[7:0] : crc[15:8];

endmodule

// File: rtl/cfg_crc_engine_chk.sv
// Checker for the check-word engine, bound to its ports.
module cfg_crc_engine_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    assert_done_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

    assert_no_rw_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_write_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en) |=> (mem_wr_en && mem_wr_addr == $past(mem_wr_addr) + 1'b1));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_en) |-> done);

endmodule

bind cfg_crc_engine cfg_crc_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr)
);

// File: tb/cfg_crc_engine_test.sv
module cfg_crc_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int CW = 9;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic [AW-1:0] dest_addr = '0;
    logic          busy, done, mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]    mem_rd_data, mem_wr_data;

    logic [7:0] mem [0:MSZ-1];
    logic [7:0] img [0:MSZ-1];
    logic       load_req = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_crc_engine #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .dest_addr(dest_addr), .busy(busy), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // Memory model: one-cycle read latency, byte writes, bulk image load.
    always @(posedge clk) begin
        if (load_req) begin
            for (int j = 0; j < MSZ; j++) mem[j] <= img[j];
        end else begin
            if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
            if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int ref_step(input int prev, input int val);
        int pd, a, b;
        pd = prev ^ val;
        a  = pd & 15;
        b  = ((pd >> 4) & 15) ^ a;
        return ((prev >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12)) & 16'hFFFF;
    endfunction

    function automatic int ref_crc(input int s, input int c);
        int acc, ev;
        acc = 16'hFFFF;
        ev  = c & ~1;
        for (int i = 0; i < ev; i++)
            acc = ref_step(acc, (int'(mem[(s + i) % MSZ]) << 8) | int'(mem[(s + i + 1) % MSZ]));
        if (c & 1) acc = ref_step(acc, int'(mem[(s + ev) % MSZ]) << 8);
        return acc;
    endfunction

    task automatic load_image();
        @(negedge clk); load_req = 1'b1;
        @(negedge clk); load_req = 1'b0;
    endtask

    // Run one job and compare against a cycle-by-cycle expectation.
    task automatic run_op(input int s, input int c, input int d, input string tag, input bit poke);
        int n, dcy, exp, reads;
        n     = (c == 0) ? 0 : (c | 1);
        dcy   = (c == 0) ? 3 : n + 4 + (c & 1);
        exp   = ref_crc(s, c);
        reads = 0;
        @(negedge clk);
        start = 1'b1; start_addr = AW'(s); byte_count = CW'(c); dest_addr = AW'(d);
        for (int k = 1; k <= dcy + 1; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke && k == 3) begin
                start = 1'b1; start_addr = AW'(s + 17); byte_count = CW'(2); dest_addr = AW'(d + 5);
            end
            if (poke && k == 4) start = 1'b0;
            chk(mem_rd_en == (k <= n), "R3", "read strobe", int'(mem_rd_en), int'(k <= n));
            if (mem_rd_en) begin
                reads++;
                chk(int'(mem_rd_addr) == (s + k - 1) % MSZ, "R3", "read address",
                    int'(mem_rd_addr), (s + k - 1) % MSZ);
            end
            chk(mem_wr_en == (k == dcy - 2 || k == dcy - 1), "R8", "write strobe",
                int'(mem_wr_en), int'(k == dcy - 2 || k == dcy - 1));
            if (k == dcy - 2) begin
                chk(int'(mem_wr_addr) == d % MSZ, "R8", "high address", int'(mem_wr_addr), d % MSZ);
                chk(int'(mem_wr_data) == (exp >> 8), "R8", "high byte", int'(mem_wr_data), exp >> 8);
            end
            if (k == dcy - 1) begin
                chk(int'(mem_wr_addr) == (d + 1) % MSZ, "R8", "low address", int'(mem_wr_addr), (d + 1) % MSZ);
                chk(int'(mem_wr_data) == (exp & 255), "R8", "low byte", int'(mem_wr_data), exp & 255);
            end
            chk(done == (k == dcy), "R9", "done", int'(done), int'(k == dcy));
            chk(busy == (k <= dcy), "R2", "busy", int'(busy), int'(k <= dcy));
        end
        chk(reads == n, "R4", "read count", reads, n);
        chk(((int'(mem[d % MSZ]) << 8) | int'(mem[(d + 1) % MSZ])) == exp, tag, "stored result",
            (int'(mem[d % MSZ]) << 8) | int'(mem[(d + 1) % MSZ]), exp);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lf;
        for (int j = 0; j < MSZ; j++) img[j] = 8'(j);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet after reset
        chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1", "reset outputs",
            {busy, done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        load_image();

        run_op(16, 0, 40, "R10", 1'b0);         // zero count: seed written
        run_op(16, 1, 40, "R7", 1'b0);          // single byte tail
        run_op(16, 2, 40, "R5", 1'b0);          // two overlapping words, extra read
        run_op(16, 3, 40, "R7", 1'b0);          // words plus tail
        run_op(100, 5, 60, "R2", 1'b1);         // start while busy ignored

        for (int j = 0; j < MSZ; j++) img[j] = 8'h00;
        load_image();
        run_op(0, 8, 200, "R6", 1'b0);

        for (int j = 0; j < MSZ; j++) img[j] = 8'hFF;
        load_image();
        run_op(3, 7, 200, "R6", 1'b0);

        lf = 16'hACE1;
        for (int j = 0; j < MSZ; j++) begin
            lf = ((lf >> 1) ^ ((lf & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            img[j] = 8'(lf);
        end
        load_image();
        run_op(0, 16'hF8, 16'hFC, "R6", 1'b0);  // header sealing
        run_op(16'hF0, 16'h21, 16'hFF, "R11", 1'b0); // read and write wrap
        run_op(16'h30, 511, 16'h10, "R11", 1'b0);    // largest count
        run_op(7, 10, 20, "R6", 1'b0);          // back to back

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule